// File: doc/BRIEF.md
# Watchdog / Alarm Down Counter

This block is a reloadable down counter with a seed register. Software loads it one byte at a time; each write sets both the live count and the seed. The block then runs in one of two modes. In the repeating alarm mode it counts once-per-second ticks and raises a flag each time it reaches zero, then reloads and carries on. In the one-shot watchdog mode it counts 4096 Hz ticks and stops at zero. Any host access to a counter byte, or a rising edge on a kick input, reloads the count from the seed. This is the normal way to keep the watchdog from firing. When the enable control is low, the counter bytes act as plain storage. The tick strobes come from an external prescaler. A write sends a one-cycle restart pulse back to that prescaler so that it can realign its phase.

The counter follows a three-state machine. `CS_HOLD` means the counter is disabled and its bytes are storage. `CS_RUN` means it is counting. `CS_HALT` means it is enabled but sitting at zero.
- Enabling moves `CS_HOLD` to `CS_RUN` when the count is non-zero, and to `CS_HALT` otherwise.
- Disabling returns either enabled state to `CS_HOLD`.
- A write or a kick selects `CS_RUN` when the loaded value is non-zero, and `CS_HALT` otherwise.
- Reaching zero moves `CS_RUN` to `CS_HALT` in watchdog mode. In alarm mode it stays in `CS_RUN`.

The interrupt request has its own machine. `IRQ_IDLE` drives the request high. `IRQ_LEVEL` holds the request low while the flag is set in alarm mode. `IRQ_PULSE` holds the request low for a fixed number of fast ticks after a watchdog expiry.
- `IRQ_IDLE` moves to `IRQ_PULSE` on a watchdog expiry when interrupts are enabled and interrupt output is selected.
- `IRQ_IDLE` moves to `IRQ_LEVEL` when the flag is set in alarm mode under the same two controls.
- `IRQ_LEVEL` returns to `IRQ_IDLE` once those conditions stop holding.
- `IRQ_PULSE` returns to `IRQ_IDLE` after its final tick and clears the flag at that moment.

Top module: `wdc_alarm_timer`

## Requirements
- R1: A write to byte index k, for k from 0 to 2, replaces bits [8k+7:8k] of both the live count and the seed. `presc_restart` is high for exactly the one cycle after the write edge.
- R2: With `mode_oneshot`=0 and a seed of S>0, the flag sets on the S-th `tick_sec` after the load. The count then reloads from the seed, so the flag sets again S ticks later.
- R3: With `mode_oneshot`=1 and a seed of S>0, the flag sets on the S-th `tick_fast` after the load. The count then stays at 0, so further ticks never set the flag again.
- R4: A host read of a counter byte, or a 0-to-1 change of `kick_in`, reloads the count from the seed. Holding `kick_in` high does not reload it again.
- R5: When the count is loaded with all zeros while enabled, neither tick input sets the flag.
- R6: When `cnt_enable`=0, ticks and kicks leave the bytes unchanged, reads return the last value written to each byte, and the flag never sets.
- R7: A `flag_wr` with `flag_wdata`=0 clears `alarm_flag`, and one with `flag_wdata`=1 leaves it unchanged. The flag sets at zero whatever the value of `irq_select`.
- R8: In alarm mode with `irq_enable`=1 and `irq_select`=1, `irq_n` goes low one cycle after the flag sets. It stays low until one cycle after the flag is cleared. With `irq_select`=0, `irq_n` stays high.
- R9: In watchdog mode with `irq_enable`=1 and `irq_select`=1, `irq_n` goes low at the expiry edge and stays low for PULSE_TICKS `tick_fast` strobes. The flag clears when the pulse ends. Clearing the flag or `irq_enable` during the pulse does not shorten it.
- R10: In alarm mode while enabled, reads return the count captured at the last `xfer_start`. Otherwise, reads return the live count.
- R11: After reset, the count, seed and snapshot are 0, `alarm_flag`=0, `irq_n`=1 and `presc_restart`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_sec | input | 1 | One-cycle strobe once per second |
| tick_fast | input | 1 | One-cycle strobe at 4096 Hz |
| xfer_start | input | 1 | Start of a host transfer; captures the read snapshot |
| acc_en | input | 1 | Host access to a counter byte this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_idx | input | IDX_W | Byte index, 0 = least significant |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the selected byte |
| cnt_enable | input | 1 | 1 = counting, 0 = storage |
| mode_oneshot | input | 1 | 0 = repeating alarm, 1 = one-shot watchdog |
| irq_enable | input | 1 | Allows the flag to drive the request |
| irq_select | input | 1 | 1 = output pin used as interrupt |
| flag_wr | input | 1 | Host write of the alarm flag |
| flag_wdata | input | 1 | Value written to the flag (only 0 acts) |
| alarm_flag | output | 1 | Terminal-count flag |
| kick_in | input | 1 | Kick strobe; its rising edge reloads the counter |
| irq_n | output | 1 | Active-low interrupt request |
| presc_restart | output | 1 | One-cycle pulse asking the prescaler to restart its phase |

## Verification
The hardest situation to reach is the watchdog pulse under interference. The flag and `irq_enable` have to be cleared while the pulse is under way, and the end of the pulse must still land on the exact tick. The bench gets there by loading a small seed and counting fast ticks to expiry. It then writes the flag to 0 and drops the interrupt enable partway through the pulse, and counts the remaining ticks one by one. The periodic behaviour is covered by sweeping several seeds in both modes, with tick-exact expected expiry points.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
    typedef enum logic [1:0] {
        CS_HOLD = 2'd0,
        CS_RUN  = 2'd1,
        CS_HALT = 2'd2
    } cnt_state_t;

    typedef enum logic [1:0] {
        IRQ_IDLE  = 2'd0,
        IRQ_LEVEL = 2'd1,
        IRQ_PULSE = 2'd2
    } irq_state_t;
endpackage

// File: rtl/wdc_kick_edge.sv
module wdc_kick_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_in,
    output logic kick_rise
);
    logic kick_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) kick_prev <= 1'b0;
        else        kick_prev <= kick_in;
    end

    assign kick_rise = kick_in & ~kick_prev;
endmodule

// File: rtl/wdc_count_fsm.sv
module wdc_count_fsm
    import wdc_pkg::*;
#(
    parameter int WIDTH = 24,
    parameter int BYTES = WIDTH / 8,
    parameter int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_sec,
    input  logic             tick_fast,
    input  logic             xfer_start,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [7:0]       acc_wdata,
    input  logic             cnt_enable,
    input  logic             mode_oneshot,
    input  logic             kick_rise,
    output logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] snap,
    output logic             expire,
    output logic             presc_restart
);
    cnt_state_t       state, state_nx;
    logic [WIDTH-1:0] seed, wr_cnt, wr_seed;
    logic             kick, tick;

    always_comb begin
        wr_cnt  = count;
        wr_seed = seed;
        for (int b = 0; b < BYTES; b++) begin
            if (acc_idx == IDX_W'(b)) begin
                wr_cnt[b*8 +: 8]  = acc_wdata;
                wr_seed[b*8 +: 8] = acc_wdata;
            end
        end
    end

    assign kick   = cnt_enable & (rd_en | kick_rise);
    assign tick   = mode_oneshot ? tick_fast : tick_sec;
    assign expire = (state == CS_RUN) & cnt_enable & ~wr_en & ~kick & tick
                    & (count == WIDTH'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CS_HOLD;
        else        state <= state_nx;
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            CS_HOLD: begin
                if (cnt_enable)
                    state_nx = (count != '0) ? CS_RUN : CS_HALT;
            end
            CS_RUN, CS_HALT: begin
                if (!cnt_enable)  state_nx = CS_HOLD;
                else if (wr_en)   state_nx = (wr_cnt != '0) ? CS_RUN : CS_HALT;
                else if (kick)    state_nx = (seed != '0) ? CS_RUN : CS_HALT;
                else if (expire)  state_nx = (!mode_oneshot && seed != '0) ? CS_RUN : CS_HALT;
            end
            default: state_nx = CS_HOLD;
        endcase
    end

    // datapath outputs: count, seed, snapshot, prescaler restart
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count         <= '0;
            seed          <= '0;
            snap          <= '0;
            presc_restart <= 1'b0;
        end else begin
            presc_restart <= wr_en;
            if (xfer_start) snap <= count;
            if (wr_en) begin
                count <= wr_cnt;
                seed  <= wr_seed;
            end else if (state != CS_HOLD && kick) begin
                count <= seed;
            end else if (state == CS_RUN && cnt_enable && tick && count != '0) begin
                if (count == WIDTH'(1)) count <= mode_oneshot ? '0 : seed;
                else                    count <= count - WIDTH'(1);
            end
        end
    end
endmodule

// File: rtl/wdc_irq_ctl.sv
module wdc_irq_ctl
    import wdc_pkg::*;
#(
    parameter int PULSE_TICKS = 1024,
    parameter int PC_W = $clog2(PULSE_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_fast,
    input  logic expire,
    input  logic mode_oneshot,
    input  logic irq_enable,
    input  logic irq_select,
    input  logic flag_wr,
    input  logic flag_wdata,
    output logic alarm_flag,
    output logic irq_n
);
    irq_state_t      state, state_nx;
    logic [PC_W-1:0] pcnt;
    logic            pulse_end, armed;

    assign armed     = irq_enable & irq_select;
    assign pulse_end = (state == IRQ_PULSE) & tick_fast
                       & (pcnt == PC_W'(PULSE_TICKS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IRQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_IDLE: begin
                if (expire && mode_oneshot && armed)            state_nx = IRQ_PULSE;
                else if (!mode_oneshot && alarm_flag && armed)  state_nx = IRQ_LEVEL;
            end
            IRQ_LEVEL: begin
                if (mode_oneshot || !alarm_flag || !armed)      state_nx = IRQ_IDLE;
            end
            IRQ_PULSE: begin
                if (pulse_end)                                  state_nx = IRQ_IDLE;
            end
            default: state_nx = IRQ_IDLE;
        endcase
    end

    // pulse timer and flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt       <= '0;
            alarm_flag <= 1'b0;
        end else begin
            if (state != IRQ_PULSE)  pcnt <= '0;
            else if (tick_fast)      pcnt <= pcnt + PC_W'(1);
            if (expire)                       alarm_flag <= 1'b1;
            else if (pulse_end)               alarm_flag <= 1'b0;
            else if (flag_wr && !flag_wdata)  alarm_flag <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        irq_n = (state == IRQ_IDLE);
    end
endmodule

// File: rtl/wdc_alarm_timer.sv
module wdc_alarm_timer #(
    parameter int WIDTH       = 24,
    parameter int PULSE_TICKS = 1024,
    parameter int BYTES       = WIDTH / 8,
    parameter int IDX_W       = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_sec,
    input  logic             tick_fast,
    input  logic             xfer_start,
    input  logic             acc_en,
    input  logic             acc_we,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [7:0]       acc_wdata,
    output logic [7:0]       acc_rdata,
    input  logic             cnt_enable,
    input  logic             mode_oneshot,
    input  logic             irq_enable,
    input  logic             irq_select,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    output logic             alarm_flag,
    input  logic             kick_in,
    output logic             irq_n,
    output logic             presc_restart
);
    logic [WIDTH-1:0] cnt_q, snap_q, rd_src;
    logic             kick_rise, expire, idx_ok, wr_en, rd_en;

    assign idx_ok = (acc_idx < IDX_W'(BYTES));
    assign wr_en  = acc_en & acc_we & idx_ok;
    assign rd_en  = acc_en & ~acc_we & idx_ok;

    wdc_kick_edge i_kick (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick_in   (kick_in),
        .kick_rise (kick_rise)
    );

    wdc_count_fsm #(.WIDTH(WIDTH), .BYTES(BYTES), .IDX_W(IDX_W)) i_count (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_sec      (tick_sec),
        .tick_fast     (tick_fast),
        .xfer_start    (xfer_start),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .acc_idx       (acc_idx),
        .acc_wdata     (acc_wdata),
        .cnt_enable    (cnt_enable),
        .mode_oneshot  (mode_oneshot),
        .kick_rise     (kick_rise),
        .count         (cnt_q),
        .snap          (snap_q),
        .expire        (expire),
        .presc_restart (presc_restart)
    );

    wdc_irq_ctl #(.PULSE_TICKS(PULSE_TICKS)) i_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_fast    (tick_fast),
        .expire       (expire),
        .mode_oneshot (mode_oneshot),
        .irq_enable   (irq_enable),
        .irq_select   (irq_select),
        .flag_wr      (flag_wr),
        .flag_wdata   (flag_wdata),
        .alarm_flag   (alarm_flag),
        .irq_n        (irq_n)
    );

    always_comb begin
        rd_src    = (cnt_enable && !mode_oneshot) ? snap_q : cnt_q;
        acc_rdata = 8'h00;
        for (int b = 0; b < BYTES; b++)
            if (acc_idx == IDX_W'(b)) acc_rdata = rd_src[b*8 +: 8];
    end
endmodule

// File: rtl/wdc_alarm_chk.sv
module wdc_alarm_chk #(
    parameter int WIDTH = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_sec,
    input logic             tick_fast,
    input logic             cnt_enable,
    input logic             acc_en,
    input logic             acc_we,
    input logic             alarm_flag,
    input logic             presc_restart,
    input logic [WIDTH-1:0] count
);
    // R7
    flag_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> ($past(tick_sec) || $past(tick_fast)));

    // R6
    flag_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(cnt_enable));

    // R1
    restart_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        presc_restart |-> $past(acc_en && acc_we));

    // R6
    storage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cnt_enable) && $past(!(acc_en && acc_we))) |-> $stable(count));
endmodule

bind wdc_alarm_timer wdc_alarm_chk #(.WIDTH(WIDTH)) i_wdc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_sec      (tick_sec),
    .tick_fast     (tick_fast),
    .cnt_enable    (cnt_enable),
    .acc_en        (acc_en),
    .acc_we        (acc_we),
    .alarm_flag    (alarm_flag),
    .presc_restart (presc_restart),
    .count         (cnt_q)
);

// File: tb/test_wdc_alarm_timer.sv
module test_wdc_alarm_timer;
    localparam int PT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_sec = 0, tick_fast = 0, xfer_start = 0;
    logic       acc_en = 0, acc_we = 0;
    logic [1:0] acc_idx = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       cnt_enable = 0, mode_oneshot = 0, irq_enable = 0, irq_select = 0;
    logic       flag_wr = 0, flag_wdata = 0, kick_in = 0;
    logic       alarm_flag, irq_n, presc_restart;

    int checks = 0, failures = 0;

    wdc_alarm_timer #(.WIDTH(24), .PULSE_TICKS(PT)) i_wdc_alarm_timer (
        .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .tick_fast(tick_fast),
        .xfer_start(xfer_start), .acc_en(acc_en), .acc_we(acc_we),
        .acc_idx(acc_idx), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .cnt_enable(cnt_enable), .mode_oneshot(mode_oneshot),
        .irq_enable(irq_enable), .irq_select(irq_select),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .alarm_flag(alarm_flag),
        .kick_in(kick_in), .irq_n(irq_n), .presc_restart(presc_restart)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic tick_s(input int n);
        for (int i = 0; i < n; i++) begin tick_sec = 1; step(); tick_sec = 0; end
    endtask

    task automatic tick_f(input int n);
        for (int i = 0; i < n; i++) begin tick_fast = 1; step(); tick_fast = 0; end
    endtask

    task automatic wr_byte(input int idx, input logic [7:0] d);
        acc_en = 1; acc_we = 1; acc_idx = 2'(idx); acc_wdata = d;
        step();
        acc_en = 0; acc_we = 0;
    endtask

    task automatic load(input int v);
        for (int b = 0; b < 3; b++) wr_byte(b, 8'((v >> (8*b)) & 255));
    endtask

    task automatic rd_byte(input int idx, output int d);
        acc_en = 1; acc_we = 0; acc_idx = 2'(idx);
        #1 d = int'(acc_rdata);
        step();
        acc_en = 0;
    endtask

    task automatic clr_flag(input logic v);
        flag_wr = 1; flag_wdata = v; step(); flag_wr = 0;
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int d;
        step(); step();
        rst_n = 1; step();
        // R11 reset state
        check("R11 flag", int'(alarm_flag), 0);
        check("R11 irq_n", int'(irq_n), 1);
        check("R11 restart", int'(presc_restart), 0);
        rd_byte(0, d); check("R11 count byte0", d, 0);

        // R6 storage while disabled
        wr_byte(0, 8'hA5);
        check("R1 restart pulse", int'(presc_restart), 1);
        step();
        check("R1 restart one cycle", int'(presc_restart), 0);
        wr_byte(1, 8'h3C); wr_byte(2, 8'hF0);
        tick_s(5); tick_f(5);
        kick_in = 1; step(); kick_in = 0; step();
        rd_byte(0, d); check("R6 byte0", d, 'hA5);
        rd_byte(1, d); check("R6 byte1", d, 'h3C);
        rd_byte(2, d); check("R6 byte2", d, 'hF0);
        check("R6 no flag", int'(alarm_flag), 0);

        // R2 alarm sweep, with irq_select=0 so the flag still sets (R7)
        cnt_enable = 1; mode_oneshot = 0; step();
        for (int s = 1; s <= 5; s++) begin
            load(s);
            if (s > 1) begin
                tick_s(s - 1);
                check("R2 before zero", int'(alarm_flag), 0);
            end
            tick_s(1);
            check("R2 flag at zero", int'(alarm_flag), 1);
            check("R8 irq high when output not selected", int'(irq_n), 1);
            clr_flag(1'b1);
            check("R7 write 1 ignored", int'(alarm_flag), 1);
            clr_flag(1'b0);
            check("R7 write 0 clears", int'(alarm_flag), 0);
            if (s > 1) begin
                tick_s(s - 1);
                check("R2 reload period", int'(alarm_flag), 0);
            end
            tick_s(1);
            check("R2 repeats", int'(alarm_flag), 1);
            clr_flag(1'b0);
        end

        // R10 snapshot
        load(10); tick_s(3);
        xfer_start = 1; step(); xfer_start = 0;
        tick_s(2);
        rd_byte(0, d); check("R10 snapshot", d, 7);

        // R8 level interrupt
        irq_enable = 1; irq_select = 1;
        load(2); tick_s(2);
        check("R8 flag", int'(alarm_flag), 1);
        step();
        check("R8 irq low", int'(irq_n), 0);
        step(); step(); step();
        check("R8 irq held", int'(irq_n), 0);
        clr_flag(1'b0); step();
        check("R8 irq released", int'(irq_n), 1);
        irq_enable = 0; irq_select = 0;

        // R3 watchdog sweep
        mode_oneshot = 1; step();
        for (int s = 1; s <= 5; s++) begin
            load(s);
            if (s > 1) begin
                tick_f(s - 1);
                check("R3 before zero", int'(alarm_flag), 0);
            end
            tick_f(1);
            check("R3 flag at zero", int'(alarm_flag), 1);
            clr_flag(1'b0);
            tick_f(2 * s + 3);
            check("R3 stopped", int'(alarm_flag), 0);
            rd_byte(0, d); check("R3 count zero", d, 0);
        end

        // R4 kick by edge, steady level does not reload
        load(4); tick_f(3);
        kick_in = 1; step();
        tick_f(3);
        check("R4 edge reloads", int'(alarm_flag), 0);
        tick_f(1);
        check("R4 steady high no reload", int'(alarm_flag), 1);
        kick_in = 0; clr_flag(1'b0);

        // R4 kick by read
        load(4); tick_f(3);
        rd_byte(0, d); check("R4 live count", d, 1);
        tick_f(3);
        check("R4 read reloads", int'(alarm_flag), 0);
        tick_f(1);
        check("R4 expires after read reload", int'(alarm_flag), 1);
        clr_flag(1'b0);

        // R5 zero load
        load(0); tick_f(40);
        check("R5 wd zero", int'(alarm_flag), 0);
        mode_oneshot = 0; step(); tick_s(40);
        check("R5 alarm zero", int'(alarm_flag), 0);
        mode_oneshot = 1; step();

        // R9 pulse without interference
        irq_enable = 1; irq_select = 1;
        load(2); tick_f(2);
        check("R9 pulse starts", int'(irq_n), 0);
        tick_f(PT - 1);
        check("R9 pulse held", int'(irq_n), 0);
        check("R9 flag during pulse", int'(alarm_flag), 1);
        tick_f(1);
        check("R9 pulse ends", int'(irq_n), 1);
        check("R9 flag self-clears", int'(alarm_flag), 0);

        // R9 pulse with flag and enable cleared mid-pulse
        load(3); tick_f(3);
        check("R9 second pulse starts", int'(irq_n), 0);
        tick_f(4);
        clr_flag(1'b0); irq_enable = 0; step();
        tick_f(PT - 5);
        check("R9 not shortened", int'(irq_n), 0);
        tick_f(1);
        check("R9 ends on time", int'(irq_n), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule